// File: doc/BRIEF.md
# Trace Pipeline Status Decoder

The decoder turns a stream of captured processor trace frames into a stream of execution events. Every frame holds a 3-bit pipeline status, a 16-bit packet field and a sync flag. For each accepted frame the block produces exactly one event. The event carries the effective status class, the tracked instruction address, the number of address bits known so far, and a flag marking trigger cycles. When an executed branch is followed by its target address, the block reassembles that address from 7-bit chunks in the packet stream. It then loads the address into its program-counter tracker. If the target used the full chunk count, the block also reports a 3-bit branch reason.

Frames enter through a valid/ready port and events leave through a valid/ready port. The event stage is a single register. While an event is waiting and `ev_ready` is low, `frame_ready` is low, and the pending event holds every field steady. Once an event has been presented, it is dropped only when `ev_ready` is high. A frame is consumed on a clock edge where `frame_valid` and `frame_ready` are both high. Its event appears on the next cycle.

Top module: `trace_flow_decoder`

## Requirements
- R1: The event kind is the frame status. The exception is status 6 (trigger), where the kind is taken from packet bits [2:0] and `ev_trig` is 1. For every other frame `ev_trig` is 0.
- R2: An event whose kind has low two bits other than 3 advances the tracked address by 4 after it is reported. An event whose kind has low two bits equal to 3 leaves the address unchanged. The reported `ev_addr` is the address before the frame.
- R3: After a frame of kind 4 (branch executed), the next two frames supply a 4-bit offset. The first frame gives bits [1:0] and the second gives bits [3:2]. Each frame contributes its status bits [1:0], or packet bits [1:0] when its status is 6.
- R4: If either of those two frames has kind 4 or 5, the pending branch is dropped. A kind-4 frame at that point starts a new branch.
- R5: After the offset is known, address bytes are ignored until a frame with sync set arrives while the offset count is 0. Each earlier frame with sync set lowers the count by one. From the arming frame on, frames with status 6 or 7 supply no bytes.
- R6: Each usable frame supplies its packet low byte first, then its high byte. Byte bits [6:0] fill successive 7-bit chunks of the target, starting with address bits [6:0]. Bit 7 set means another byte follows. A byte with bit 7 clear ends the target, and so does the fifth byte regardless of bit 7. On the frame that ends the target, `ev_tdone` is 1 and `ev_addr` shows the target. The target is the chunk bits merged over the bits above them taken from the tracked address. The target then becomes the tracked address, without the +4 of R2.
- R7: `ev_bits` is the largest value of min(32, 7 × chunks) over all completed targets since reset. It never decreases.
- R8: When a target ends on its fifth byte, `ev_rsn_vld` is 1 and `ev_rsn` equals that byte's bits [6:4]. Only bits [3:0] of that byte enter address bits [31:28].
- R9: `frame_ready` is low exactly while an event is pending and `ev_ready` is low. During that stall the event fields stay constant.
- R10: A synchronous reset clears the tracked address, the bit count, any branch in progress and `ev_valid`.
- R11: A kind-4 frame that arrives while target bytes are being gathered abandons the partial target and begins a new offset phase. That frame supplies no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_valid | input | 1 | Frame present |
| frame_ready | output | 1 | Frame accepted this cycle when valid |
| frame_stat | input | 3 | Pipeline status of the frame |
| frame_pkt | input | PKT_W (16) | Packet field, two address bytes |
| frame_sync | input | 1 | Sync flag of the frame |
| ev_valid | output | 1 | Event present |
| ev_ready | input | 1 | Consumer takes the event |
| ev_kind | output | 3 | Effective status of the cycle |
| ev_addr | output | ADDR_W (32) | Tracked address, or the new target when `ev_tdone` is set |
| ev_bits | output | 6 | Number of known address bits |
| ev_trig | output | 1 | Frame was a trigger cycle |
| ev_tdone | output | 1 | A branch target completed on this frame |
| ev_rsn_vld | output | 1 | `ev_rsn` is meaningful |
| ev_rsn | output | 3 | Branch reason from the fifth byte |

## Verification
The tests first sweep all raw statuses and all statuses displaced into the packet by a trigger. This separates the kind decode from the address-increment rule.

Branch sequences then vary the following:
- the offset source: status bits versus trigger packet bits;
- the number of sync frames skipped before arming;
- status-7 frames inside the byte run;
- targets of one, two and five bytes.

These cases distinguish byte order, chunk placement, merge masking, bit-count growth and reason extraction.

Further sequences put a branch status in each of the two offset slots and in the middle of gathering. This shows dropping apart from restarting. A stall with `ev_ready` low and a mid-run reset cover the handshake and the cleared state.

// File: rtl/trace_dec_pkg.sv
package trace_dec_pkg;
  localparam logic [2:0] K_EXEC    = 3'd0;
  localparam logic [2:0] K_NOEXEC  = 3'd1;
  localparam logic [2:0] K_EXEC_NP = 3'd2;
  localparam logic [2:0] K_WAIT    = 3'd3;
  localparam logic [2:0] K_BR      = 3'd4;
  localparam logic [2:0] K_BRN     = 3'd5;
  localparam logic [2:0] K_TRIG    = 3'd6;
  localparam logic [2:0] K_OFF     = 3'd7;

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_OFS1 = 2'd1,
    PH_OFS2 = 2'd2,
    PH_GATH = 2'd3
  } phase_e;
endpackage

// File: rtl/trace_frame_unpack.sv
module trace_frame_unpack
  import trace_dec_pkg::*;
(
  input  logic [2:0] raw,
  input  logic [2:0] pkt_lo,
  output logic [2:0] eff,
  output logic       trig,
  output logic [1:0] ofs_bits,
  output logic       pkt_ok,
  output logic       inc,
  output logic       br_exec,
  output logic       br_any
);
  always_comb begin
    trig     = (raw == K_TRIG);
    eff      = trig ? pkt_lo : raw;
    ofs_bits = trig ? pkt_lo[1:0] : raw[1:0];
    pkt_ok   = !((raw == K_TRIG) || (raw == K_OFF));
    inc      = (eff[1:0] != 2'b11);
    br_exec  = (eff == K_BR);
    br_any   = (eff == K_BR) || (eff == K_BRN);
  end
endmodule

// File: rtl/trace_chunk_gather.sv
module trace_chunk_gather #(
  parameter int ADDR_W  = 32,
  parameter int CHUNK_W = 7,
  parameter int PKT_W   = 16,
  parameter int MAXB    = 5,
  parameter int KW      = 3,
  parameter int RSN_LSB = 4
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic [KW-1:0]     k_i,
  input  logic [PKT_W-1:0]  pkt,
  output logic [ADDR_W-1:0] tgt_o,
  output logic [KW-1:0]     k_o,
  output logic              done,
  output logic              rsn_vld,
  output logic [2:0]        rsn
);
  localparam int NL = PKT_W / 8;

  function automatic logic [ADDR_W-1:0] put_chunk(
    input logic [ADDR_W-1:0]  v,
    input logic [KW-1:0]      k,
    input logic [CHUNK_W-1:0] c
  );
    logic [ADDR_W-1:0] r;
    r = v;
    for (int j = 0; j < ADDR_W; j++)
      if ((j / CHUNK_W) == int'(k)) r[j] = c[j % CHUNK_W];
    return r;
  endfunction

  logic [ADDR_W-1:0] t   [0:NL];
  logic [KW-1:0]     kk  [0:NL];
  logic              act [0:NL];
  logic [NL-1:0]     fin_l;
  logic [NL-1:0]     rv_l;
  logic [2:0]        rs_l [0:NL-1];

  assign t[0]   = tgt_i;
  assign kk[0]  = k_i;
  assign act[0] = en;

  // one lane per packet byte, low byte first
  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [7:0] b;
    logic       last;
    assign b         = pkt[8*i +: 8];
    assign last      = (({1'b0, kk[i]} + 1'b1) == (KW+1)'(MAXB));
    assign fin_l[i]  = act[i] && (!b[7] || last);
    assign act[i+1]  = act[i] && !fin_l[i];
    assign t[i+1]    = act[i] ? put_chunk(t[i], kk[i], b[CHUNK_W-1:0]) : t[i];
    assign kk[i+1]   = act[i] ? kk[i] + 1'b1 : kk[i];
    assign rv_l[i]   = fin_l[i] && last;
    assign rs_l[i]   = b[RSN_LSB +: 3];
  end

  always_comb begin
    rsn = '0;
    for (int i = 0; i < NL; i++)
      if (rv_l[i]) rsn = rs_l[i];
  end

  assign tgt_o   = t[NL];
  assign k_o     = kk[NL];
  assign done    = |fin_l;
  assign rsn_vld = |rv_l;
endmodule

// File: rtl/trace_flow_decoder.sv
module trace_flow_decoder
  import trace_dec_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PKT_W   = 16,
  parameter int CHUNK_W = 7,
  parameter int RSN_LSB = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         frame_valid,
  output logic                         frame_ready,
  input  logic [2:0]                   frame_stat,
  input  logic [PKT_W-1:0]             frame_pkt,
  input  logic                         frame_sync,
  output logic                         ev_valid,
  input  logic                         ev_ready,
  output logic [2:0]                   ev_kind,
  output logic [ADDR_W-1:0]            ev_addr,
  output logic [$clog2(ADDR_W+1)-1:0]  ev_bits,
  output logic                         ev_trig,
  output logic                         ev_tdone,
  output logic                         ev_rsn_vld,
  output logic [2:0]                   ev_rsn
);
  localparam int MAXB   = (ADDR_W + CHUNK_W - 1) / CHUNK_W;
  localparam int KW     = $clog2(MAXB + 1);
  localparam int BITS_W = $clog2(ADDR_W + 1);

  phase_e              ph_q, ph_n;
  logic [1:0]          ofs_lo_q, ofs_lo_n;
  logic [3:0]          cnt_q, cnt_n;
  logic                armed_q, armed_n;
  logic [KW-1:0]       k_q, k_n;
  logic [ADDR_W-1:0]   tgt_q, tgt_n;
  logic [ADDR_W-1:0]   pc_q, pc_n;
  logic [BITS_W-1:0]   bits_q, bits_n;

  logic [2:0] eff;
  logic       trig, pkt_ok, inc, br_exec, br_any;
  logic [1:0] ofs_bits;

  trace_frame_unpack u_unpack (
    .raw      (frame_stat),
    .pkt_lo   (frame_pkt[2:0]),
    .eff      (eff),
    .trig     (trig),
    .ofs_bits (ofs_bits),
    .pkt_ok   (pkt_ok),
    .inc      (inc),
    .br_exec  (br_exec),
    .br_any   (br_any)
  );

  logic              acc, arm_now, g_en, g_done, g_rv, tdone;
  logic [ADDR_W-1:0] g_tgt, lmask, merged;
  logic [KW-1:0]     g_k;
  logic [2:0]        g_rsn;
  int                kb;

  assign frame_ready = !ev_valid || ev_ready;
  assign acc         = frame_valid && frame_ready;
  assign arm_now     = armed_q || (frame_sync && (cnt_q == 4'd0));
  assign g_en        = acc && (ph_q == PH_GATH) && !br_exec && arm_now && pkt_ok;

  trace_chunk_gather #(
    .ADDR_W (ADDR_W), .CHUNK_W (CHUNK_W), .PKT_W (PKT_W),
    .MAXB (MAXB), .KW (KW), .RSN_LSB (RSN_LSB)
  ) u_gather (
    .en      (g_en),
    .tgt_i   (tgt_q),
    .k_i     (k_q),
    .pkt     (frame_pkt),
    .tgt_o   (g_tgt),
    .k_o     (g_k),
    .done    (g_done),
    .rsn_vld (g_rv),
    .rsn     (g_rsn)
  );

  assign tdone = g_en && g_done;

  always_comb begin
    for (int j = 0; j < ADDR_W; j++) lmask[j] = (j < int'(g_k) * CHUNK_W);
    merged = (pc_q & ~lmask) | (g_tgt & lmask);
    kb = int'(g_k) * CHUNK_W;
    if (kb > ADDR_W) kb = ADDR_W;
  end

  always_comb begin
    ph_n     = ph_q;
    ofs_lo_n = ofs_lo_q;
    cnt_n    = cnt_q;
    armed_n  = armed_q;
    k_n      = k_q;
    tgt_n    = tgt_q;
    bits_n   = bits_q;
    pc_n     = pc_q + (inc ? ADDR_W'(4) : ADDR_W'(0));
    case (ph_q)
      PH_RUN: if (br_exec) ph_n = PH_OFS1;
      PH_OFS1: begin
        if (br_any) ph_n = br_exec ? PH_OFS1 : PH_RUN;
        else begin
          ofs_lo_n = ofs_bits;
          ph_n     = PH_OFS2;
        end
      end
      PH_OFS2: begin
        if (br_any) ph_n = br_exec ? PH_OFS1 : PH_RUN;
        else begin
          cnt_n   = {ofs_bits, ofs_lo_q};
          armed_n = 1'b0;
          k_n     = '0;
          tgt_n   = '0;
          ph_n    = PH_GATH;
        end
      end
      default: begin
        if (br_exec) ph_n = PH_OFS1;
        else begin
          if (!armed_q && frame_sync && (cnt_q != 4'd0)) cnt_n = cnt_q - 4'd1;
          armed_n = arm_now;
          if (g_en) begin
            tgt_n = g_tgt;
            k_n   = g_k;
          end
          if (tdone) begin
            ph_n = PH_RUN;
            pc_n = merged;
            if (BITS_W'(kb) > bits_q) bits_n = BITS_W'(kb);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= PH_RUN;
      ofs_lo_q   <= '0;
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      k_q        <= '0;
      tgt_q      <= '0;
      pc_q       <= '0;
      bits_q     <= '0;
      ev_valid   <= 1'b0;
      ev_kind    <= '0;
      ev_addr    <= '0;
      ev_bits    <= '0;
      ev_trig    <= 1'b0;
      ev_tdone   <= 1'b0;
      ev_rsn_vld <= 1'b0;
      ev_rsn     <= '0;
    end else if (acc) begin
      ph_q       <= ph_n;
      ofs_lo_q   <= ofs_lo_n;
      cnt_q      <= cnt_n;
      armed_q    <= armed_n;
      k_q        <= k_n;
      tgt_q      <= tgt_n;
      pc_q       <= pc_n;
      bits_q     <= bits_n;
      ev_valid   <= 1'b1;
      ev_kind    <= eff;
      ev_addr    <= tdone ? merged : pc_q;
      ev_bits    <= bits_n;
      ev_trig    <= trig;
      ev_tdone   <= tdone;
      ev_rsn_vld <= tdone && g_rv;
      ev_rsn     <= g_rsn;
    end else if (ev_ready) begin
      ev_valid <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_addr) && $stable(ev_kind) && $stable(ev_tdone)));

  assert_bits_grow_R7: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> (ev_bits >= $past(ev_bits)));

  assert_bits_cap_R7: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> (int'(ev_bits) <= ADDR_W));

  assert_reason_full_R8: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_rsn_vld) |-> (ev_tdone && int'(ev_bits) == ADDR_W));

  assert_target_bits_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_tdone) |-> (ev_bits != '0));

  assert_wait_arm_R5: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_GATH && cnt_q != 4'd0) |-> !armed_q);
endmodule

// File: tb/trace_flow_decoder_bench.sv
`timescale 1ns/1ps
module trace_flow_decoder_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        frame_valid, frame_ready, frame_sync;
  logic [2:0]  frame_stat;
  logic [15:0] frame_pkt;
  logic        ev_valid, ev_ready, ev_trig, ev_tdone, ev_rsn_vld;
  logic [2:0]  ev_kind, ev_rsn;
  logic [31:0] ev_addr;
  logic [5:0]  ev_bits;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_pc;
  int exp_bits;
  bit finished = 0;

  always #2 clk = ~clk;

  trace_flow_decoder u_trace_flow_decoder (
    .clk (clk), .rst (rst),
    .frame_valid (frame_valid), .frame_ready (frame_ready),
    .frame_stat (frame_stat), .frame_pkt (frame_pkt), .frame_sync (frame_sync),
    .ev_valid (ev_valid), .ev_ready (ev_ready),
    .ev_kind (ev_kind), .ev_addr (ev_addr), .ev_bits (ev_bits),
    .ev_trig (ev_trig), .ev_tdone (ev_tdone),
    .ev_rsn_vld (ev_rsn_vld), .ev_rsn (ev_rsn)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] pc, input logic [31:0] ch, input int k);
    logic [31:0] m;
    m = (k * 7 >= 32) ? 32'hFFFF_FFFF : ((32'h1 << (k * 7)) - 32'h1);
    return (pc & ~m) | (ch & m);
  endfunction

  // called at a falling edge; returns at the next falling edge with the event checked
  task automatic send(input logic [2:0] raw, input logic [15:0] pkt, input logic sync,
                      input int k, input logic [31:0] ch, input logic [2:0] rsn, input string tag);
    logic [2:0] eff;
    logic [31:0] ea;
    int nb;
    eff = (raw == 3'd6) ? pkt[2:0] : raw;
    frame_valid = 1'b1; frame_stat = raw; frame_pkt = pkt; frame_sync = sync;
    @(negedge clk);
    ea = (k > 0) ? merge(exp_pc, ch, k) : exp_pc;
    if (k > 0) begin
      nb = (k * 7 > 32) ? 32 : k * 7;
      if (nb > exp_bits) exp_bits = nb;
    end
    check(ev_valid == 1'b1, "R9 event valid", 32'(ev_valid), 32'd1);
    check(ev_kind == eff, "R1 kind", 32'(ev_kind), 32'(eff));
    check(ev_trig == (raw == 3'd6), "R1 trigger flag", 32'(ev_trig), 32'(raw == 3'd6));
    check(ev_tdone == (k > 0), {tag, " target done"}, 32'(ev_tdone), 32'(k > 0));
    check(ev_addr == ea, {tag, " address"}, ev_addr, ea);
    check(int'(ev_bits) == exp_bits, "R7 bit count", 32'(ev_bits), 32'(exp_bits));
    check(ev_rsn_vld == (k == 5), "R8 reason valid", 32'(ev_rsn_vld), 32'(k == 5));
    if (k == 5) check(ev_rsn == rsn, "R8 reason", 32'(ev_rsn), 32'(rsn));
    if (k > 0) exp_pc = ea;
    else if (eff[1:0] != 2'b11) exp_pc = exp_pc + 32'd4;
  endtask

  initial begin
    logic [31:0] prev;
    rst = 1'b1; frame_valid = 1'b0; frame_stat = '0; frame_pkt = '0; frame_sync = 1'b0; ev_ready = 1'b1;
    exp_pc = '0; exp_bits = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(ev_valid == 1'b0, "R10 ev_valid after reset", 32'(ev_valid), 32'd0);
    check(frame_ready == 1'b1, "R10 ready after reset", 32'(frame_ready), 32'd1);
    rst = 1'b0;

    // R1/R2 sweep of raw statuses and displaced statuses
    for (int s = 0; s < 8; s++) if (s != 4) send(3'(s), 16'h0000, 1'b0, 0, 0, 0, "R2");
    for (int s = 0; s < 8; s++) if (s != 4) send(3'd6, 16'(s), 1'b1, 0, 0, 0, "R1");

    // R6 two-byte target, offset 0
    send(3'd4, 16'h0000, 1'b0, 0, 0, 0, "R6");
    send(3'd0, 16'h0000, 1'b0, 0, 0, 0, "R3");
    send(3'd0, 16'h0000, 1'b0, 0, 0, 0, "R3");
    send(3'd0, 16'h1285, 1'b1, 2, 32'h0000_0905, 0, "R6");
    send(3'd0, 16'h0000, 1'b0, 0, 0, 0, "R2");

    // R6 single byte keeps bit count at 14 (R7)
    send(3'd4, 16'h0000, 1'b0, 0, 0, 0, "R6");
    send(3'd0, 16'h0000, 1'b0, 0, 0, 0, "R3");
    send(3'd0, 16'h0000, 1'b0, 0, 0, 0, "R3");
    send(3'd2, 16'hFF0A, 1'b1, 1, 32'h0000_000A, 0, "R7");

    // R5/R8 offset 1 from status bits, skipped sync, idle frame, five-byte target
    send(3'd4, 16'h0000, 1'b0, 0, 0, 0, "R3");
    send(3'd1, 16'h0000, 1'b0, 0, 0, 0, "R3");
    send(3'd0, 16'h0000, 1'b0, 0, 0, 0, "R3");
    send(3'd0, 16'hFFFF, 1'b1, 0, 0, 0, "R5");
    send(3'd0, 16'hFFFF, 1'b0, 0, 0, 0, "R5");
    send(3'd0, 16'h8281, 1'b1, 0, 0, 0, "R5");
    send(3'd7, 16'hFFFF, 1'b0, 0, 0, 0, "R5");
    send(3'd3, 16'h8483, 1'b0, 0, 0, 0, "R6");
    send(3'd0, 16'h0035, 1'b0, 5, 32'h5080_C101, 3'd3, "R8");

    // R3 offset from trigger packet bits, R5 trigger frame arms but gives no bytes
    send(3'd4, 16'h0000, 1'b0, 0, 0, 0, "R3");
    send(3'd6, 16'h0001, 1'b0, 0, 0, 0, "R3");
    send(3'd0, 16'h0000, 1'b0, 0, 0, 0, "R3");
    send(3'd0, 16'h0101, 1'b1, 0, 0, 0, "R5");
    send(3'd6, 16'h0000, 1'b1, 0, 0, 0, "R5");
    send(3'd0, 16'h0033, 1'b0, 1, 32'h0000_0033, 0, "R3");

    // R4 drop on first slot, then bytes are ignored
    send(3'd4, 16'h0000, 1'b0, 0, 0, 0, "R4");
    send(3'd5, 16'h0000, 1'b0, 0, 0, 0, "R4");
    send(3'd0, 16'h0011, 1'b1, 0, 0, 0, "R4");
    // R4 new branch on second slot restarts
    send(3'd4, 16'h0000, 1'b0, 0, 0, 0, "R4");
    send(3'd0, 16'h0000, 1'b0, 0, 0, 0, "R4");
    send(3'd4, 16'h0000, 1'b0, 0, 0, 0, "R4");
    send(3'd0, 16'h0000, 1'b0, 0, 0, 0, "R4");
    send(3'd0, 16'h0000, 1'b0, 0, 0, 0, "R4");
    send(3'd0, 16'h0022, 1'b1, 1, 32'h0000_0022, 0, "R4");

    // R11 branch while gathering abandons partial target
    send(3'd4, 16'h0000, 1'b0, 0, 0, 0, "R11");
    send(3'd0, 16'h0000, 1'b0, 0, 0, 0, "R11");
    send(3'd0, 16'h0000, 1'b0, 0, 0, 0, "R11");
    send(3'd0, 16'h8899, 1'b1, 0, 0, 0, "R11");
    send(3'd4, 16'h0055, 1'b0, 0, 0, 0, "R11");
    send(3'd0, 16'h0000, 1'b0, 0, 0, 0, "R11");
    send(3'd0, 16'h0000, 1'b0, 0, 0, 0, "R11");
    send(3'd0, 16'h0044, 1'b1, 1, 32'h0000_0044, 0, "R11");

    // R9 back-pressure
    prev = ev_addr;
    ev_ready = 1'b0;
    frame_valid = 1'b1; frame_stat = 3'd0; frame_pkt = '0; frame_sync = 1'b0;
    @(negedge clk);
    check(frame_ready == 1'b0, "R9 ready low in stall", 32'(frame_ready), 32'd0);
    check(ev_valid == 1'b1, "R9 event held", 32'(ev_valid), 32'd1);
    check(ev_addr == prev, "R9 address held", ev_addr, prev);
    ev_ready = 1'b1;
    @(negedge clk);
    check(ev_addr == exp_pc, "R9 frame taken after stall", ev_addr, exp_pc);
    exp_pc = exp_pc + 32'd4;
    frame_valid = 1'b0;
    @(negedge clk);
    check(ev_valid == 1'b0, "R9 event drained", 32'(ev_valid), 32'd0);

    // R10 mid-run reset
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(ev_valid == 1'b0, "R10 ev_valid cleared", 32'(ev_valid), 32'd0);
    rst = 1'b0;
    exp_pc = '0; exp_bits = 0;
    send(3'd0, 16'h0000, 1'b0, 0, 0, 0, "R10");
    frame_valid = 1'b0;
    @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule